// File: doc/BRIEF.md
# Ramp-Sweep Code Fault Classifier

This block watches the output codes of an N-bit analogue-to-digital converter while an ideal linear ramp is applied to its input. For every ramp step it is given the code the ramp should produce (the step index) and the code the converter actually returned. A fault-free converter yields an ascending staircase in which every code appears. The block records what it sees during one sweep and, when the sweep ends, reports three fault classes. Missing codes are codes that never appeared. Stuck bits are output bits that never changed level. A constant offset is a fixed signed difference between the actual and expected codes.

An offset can be corrected afterwards by subtracting it, but missing codes and stuck bits cannot. For that reason the offset is reported as a separate flag with its signed value, apart from the two masks. A `start` pulse clears all records. A step flagged with `last_step` closes the sweep, and the report appears shortly after as a one-cycle strobe.

Top module: `adc_ramp_checker`

## Requirements
- R1: After reset, `report_valid` is 0 and every report output (`missing_mask`, `stuck0_mask`, `stuck1_mask`, `offset_flag`, `offset_value`) is 0.
- R2: In a report, bit c of `missing_mask` is 1 exactly when code c never appeared on `act_code` during an accepted step since the last `start`. A step is accepted when `step_valid` is 1 and `start` is 0, and cycles with `step_valid` at 0 are ignored.
- R3: In a report, bit i of `stuck0_mask` is 1 exactly when bit i of `act_code` was never 1 in any accepted step.
- R4: In a report, bit i of `stuck1_mask` is 1 exactly when bit i of `act_code` was never 0 in any accepted step.
- R5: A step is saturated when `act_code` is 0 or the all-ones code. `offset_flag` is 1 exactly when at least one accepted step was not saturated and every such step had the same nonzero difference `act_code - exp_code`.
- R6: `offset_value` is an N+1-bit two's-complement number. It equals that common difference when all accepted non-saturated steps agree, which includes a common difference of zero. In every other case it is 0.
- R7: `start` clears all records. An accepted step in the same cycle as `start` is not possible, because a step that coincides with `start` is discarded.
- R8: `report_valid` is 1 for exactly one cycle. It rises two clock edges after the edge that samples the accepted step carrying `last_step`. The report outputs keep their values until the next report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears all sweep records |
| step_valid | input | 1 | A ramp step is presented this cycle |
| last_step | input | 1 | This step ends the sweep |
| exp_code | input | CODE_W | Ideal code for this step |
| act_code | input | CODE_W | Code the converter produced |
| report_valid | output | 1 | One-cycle report strobe |
| missing_mask | output | 2**CODE_W | Codes never observed |
| stuck0_mask | output | CODE_W | Bits never observed high |
| stuck1_mask | output | CODE_W | Bits never observed low |
| offset_flag | output | 1 | Constant nonzero offset found |
| offset_value | output | CODE_W+1 | Signed common offset |

## Verification
Some properties can be checked on every cycle, and the assertions cover those. The report strobe never lasts two cycles, and it always follows a closing step by exactly two edges. Any accepted code is marked in the seen-map on the next cycle, a `start` leaves the map empty, and a raised offset flag never comes with a zero value. Whether the masks and the offset classification are correct for a whole sweep can only be shown by the bench's scenarios. These cover a clean ramp, a missing code, a bit stuck low, a bit stuck high, positive and negative offsets with clipping at the ends of the range, an ignored idle step, and a step that collides with `start`.

// File: rtl/adc_chk_pkg.sv
package adc_chk_pkg;
  typedef enum logic [1:0] {
    OFS_EMPTY  = 2'd0,
    OFS_MATCH  = 2'd1,
    OFS_BROKEN = 2'd2
  } ofs_state_e;
endpackage

// File: rtl/code_seen_map.sv
module code_seen_map #(
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     upd,
  input  logic [CODE_W-1:0]        code,
  output logic [(1<<CODE_W)-1:0]   seen
);
  localparam int NCODES = 1 << CODE_W;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen <= '0;
    end else if (upd) begin
      seen[code] <= 1'b1;
    end
  end

  AST_MARK_SEEN: assert property (@(posedge clk) disable iff (rst)
    (upd && !clr) |=> seen[$past(code)]) else $error("seen bit not set"); // R2

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr |=> (seen == '0)) else $error("clear left codes"); // R7

  initial if (NCODES < 2) $error("bad width");
endmodule

// File: rtl/bit_level_tracker.sv
module bit_level_tracker #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] saw_high,
  output logic [CODE_W-1:0] saw_low
);
  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        saw_high[b] <= 1'b0;
        saw_low[b]  <= 1'b0;
      end else if (upd) begin
        if (code[b]) saw_high[b] <= 1'b1;
        else         saw_low[b]  <= 1'b1;
      end
    end
  end

  AST_LEVEL_SEEN: assert property (@(posedge clk) disable iff (rst)
    (upd && !clr) |=> ((saw_high | saw_low) == '1)) else $error("level not recorded"); // R3
endmodule

// File: rtl/offset_tracker.sv
module offset_tracker
  import adc_chk_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     upd,
  input  logic [CODE_W-1:0]        exp_code,
  input  logic [CODE_W-1:0]        act_code,
  output ofs_state_e               state,
  output logic signed [CODE_W:0]   diff
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic signed [CODE_W:0] diff_now;
  logic                   clipped;

  always_comb begin
    diff_now = $signed({1'b0, act_code}) - $signed({1'b0, exp_code});
    clipped  = (act_code == '0) || (act_code == CODE_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state <= OFS_EMPTY;
      diff  <= '0;
    end else if (upd && !clipped) begin
      case (state)
        OFS_EMPTY: begin
          state <= OFS_MATCH;
          diff  <= diff_now;
        end
        OFS_MATCH: if (diff_now != diff) state <= OFS_BROKEN;
        default:   state <= OFS_BROKEN;
      endcase
    end
  end

  AST_BROKEN_STICKS: assert property (@(posedge clk) disable iff (rst)
    (state == OFS_BROKEN && !clr) |=> (state == OFS_BROKEN)) else $error("broken state left"); // R5
endmodule

// File: rtl/adc_ramp_checker.sv
module adc_ramp_checker
  import adc_chk_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        step_valid,
  input  logic                        last_step,
  input  logic [CODE_W-1:0]           exp_code,
  input  logic [CODE_W-1:0]           act_code,
  output logic                        report_valid,
  output logic [(1<<CODE_W)-1:0]      missing_mask,
  output logic [CODE_W-1:0]           stuck0_mask,
  output logic [CODE_W-1:0]           stuck1_mask,
  output logic                        offset_flag,
  output logic signed [CODE_W:0]      offset_value
);
  localparam int NCODES = 1 << CODE_W;

  logic                   accept;
  logic                   fin_q;
  logic [NCODES-1:0]      seen;
  logic [CODE_W-1:0]      saw_high, saw_low;
  ofs_state_e             ofs_state;
  logic signed [CODE_W:0] ofs_diff;

  assign accept = step_valid && !start;

  code_seen_map #(.CODE_W(CODE_W)) u_map (
    .clk(clk), .rst(rst), .clr(start), .upd(accept), .code(act_code), .seen(seen)
  );

  bit_level_tracker #(.CODE_W(CODE_W)) u_bits (
    .clk(clk), .rst(rst), .clr(start), .upd(accept), .code(act_code),
    .saw_high(saw_high), .saw_low(saw_low)
  );

  offset_tracker #(.CODE_W(CODE_W)) u_ofs (
    .clk(clk), .rst(rst), .clr(start), .upd(accept),
    .exp_code(exp_code), .act_code(act_code), .state(ofs_state), .diff(ofs_diff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_q        <= 1'b0;
      report_valid <= 1'b0;
      missing_mask <= '0;
      stuck0_mask  <= '0;
      stuck1_mask  <= '0;
      offset_flag  <= 1'b0;
      offset_value <= '0;
    end else begin
      fin_q        <= accept && last_step;
      report_valid <= fin_q;
      if (fin_q) begin
        missing_mask <= ~seen;
        stuck0_mask  <= ~saw_high;
        stuck1_mask  <= ~saw_low;
        offset_flag  <= (ofs_state == OFS_MATCH) && (ofs_diff != '0);
        offset_value <= (ofs_state == OFS_MATCH) ? ofs_diff : '0;
      end
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    report_valid |=> !report_valid) else $error("strobe too long"); // R8

  AST_REPORT_TIMING: assert property (@(posedge clk) disable iff (rst)
    $rose(report_valid) |-> $past(step_valid && last_step && !start, 2)) else $error("stray report"); // R8

  AST_FLAG_VALUE: assert property (@(posedge clk) disable iff (rst)
    offset_flag |-> (offset_value != '0)) else $error("flag with zero offset"); // R6

  AST_HOLD_REPORT: assert property (@(posedge clk) disable iff (rst)
    (!$past(fin_q) && $past(!rst)) |-> $stable(missing_mask)) else $error("report changed"); // R8
endmodule

// File: tb/tb_adc_ramp_checker.sv
module tb_adc_ramp_checker;
  localparam int W  = 4;
  localparam int NC = 1 << W;

  typedef struct {
    logic [NC-1:0] miss;
    logic [W-1:0]  s0;
    logic [W-1:0]  s1;
    logic          flag;
    logic [W:0]    val;
  } rep_t;

  logic clk = 0;
  logic rst = 1;
  logic start = 0, step_valid = 0, last_step = 0;
  logic [W-1:0] exp_code = '0, act_code = '0;
  logic report_valid, offset_flag;
  logic [NC-1:0] missing_mask;
  logic [W-1:0] stuck0_mask, stuck1_mask;
  logic signed [W:0] offset_value;

  int errors = 0;
  int checks = 0;
  rep_t q[$];
  rep_t last_exp;
  bit prev_rv = 0;

  always #10 clk = ~clk;

  adc_ramp_checker #(.CODE_W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .step_valid(step_valid),
    .last_step(last_step), .exp_code(exp_code), .act_code(act_code),
    .report_valid(report_valid), .missing_mask(missing_mask),
    .stuck0_mask(stuck0_mask), .stuck1_mask(stuck1_mask),
    .offset_flag(offset_flag), .offset_value(offset_value)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int fault(input int kind, input int i);
    int a;
    case (kind)
      1: a = (i == NC/2 + 1) ? NC/2 : i;
      2: a = i & ~2;
      3: a = i | (NC/2);
      4: a = (i + 2 > NC-1) ? NC-1 : i + 2;
      5: a = (i - 3 < 0) ? 0 : i - 3;
      default: a = i;
    endcase
    return a;
  endfunction

  // monitor: pops expected reports and compares
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_rv && report_valid) chk(0, "R8 pulse width", 1, 0);
      if (report_valid) begin
        if (q.size() == 0) chk(0, "R8 unexpected report", 1, 0);
        else begin
          rep_t e;
          e = q.pop_front();
          chk(missing_mask == e.miss, "R2 missing", missing_mask, e.miss);
          chk(stuck0_mask == e.s0, "R3 stuck0", stuck0_mask, e.s0);
          chk(stuck1_mask == e.s1, "R4 stuck1", stuck1_mask, e.s1);
          chk(offset_flag == e.flag, "R5 offset flag", offset_flag, e.flag);
          chk(offset_value == e.val, "R6 offset value", offset_value, e.val);
        end
      end
      prev_rv = report_valid;
    end
  end

  task automatic sweep(input int kind, input bit collide);
    rep_t e;
    logic [NC-1:0] seen = '0;
    logic [W-1:0] hi = '0, lo = '0;
    int ost = 0;
    int od = 0;
    @(negedge clk);
    start = 1;
    if (collide) begin
      step_valid = 1; exp_code = '0; act_code = '0;
    end
    @(negedge clk);
    start = 0;
    for (int i = (collide ? 1 : 0); i < NC; i++) begin
      int a;
      if (i == 5) begin
        // idle cycle with a garbage code: must be ignored (R2)
        step_valid = 0; exp_code = '0; act_code = W'(NC-1);
        @(negedge clk);
      end
      a = fault(kind, i);
      step_valid = 1; exp_code = W'(i); act_code = W'(a);
      last_step = (i == NC-1);
      seen[a] = 1'b1;
      hi = hi | W'(a);
      lo = lo | ~W'(a);
      if (a != 0 && a != NC-1) begin
        if (ost == 0) begin ost = 1; od = a - i; end
        else if (ost == 1 && (a - i) != od) ost = 2;
      end
      @(negedge clk);
    end
    step_valid = 0; last_step = 0;
    e.miss = ~seen; e.s0 = ~hi; e.s1 = ~lo;
    e.flag = (ost == 1) && (od != 0);
    e.val  = (ost == 1) ? od[W:0] : '0;
    q.push_back(e);
    last_exp = e;
    chk(report_valid == 0, "R8 early strobe", report_valid, 0);
    @(negedge clk);
    chk(report_valid == 1, "R8 strobe timing", report_valid, 1);
    repeat (3) @(negedge clk);
    chk(missing_mask == last_exp.miss, "R8 hold", missing_mask, last_exp.miss);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(report_valid == 0, "R1 strobe", report_valid, 0);
    chk(missing_mask == 0, "R1 missing", missing_mask, 0);
    chk(stuck0_mask == 0 && stuck1_mask == 0, "R1 stuck", {stuck0_mask, stuck1_mask}, 0);
    chk(offset_flag == 0 && offset_value == 0, "R1 offset", {offset_flag, offset_value}, 0);
    sweep(0, 0);  // clean ramp
    sweep(1, 0);  // missing code
    sweep(2, 0);  // bit 1 stuck low
    sweep(3, 0);  // top bit stuck high
    sweep(4, 0);  // offset +2
    sweep(5, 0);  // offset -3
    sweep(0, 1);  // R7: step coinciding with start discarded, code 0 missing
    chk(q.size() == 0, "R8 reports outstanding", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule